// File: doc/BRIEF.md
# Power-management operating-mode controller

This block tracks which operating mode a power-management device is in and drives the enables that follow from it. It holds five states: `PM_OFF` (no supply), `PM_RST` (full application reset), `PM_PDN` (low-power, system domain not fully up), `PM_BOOT` (system domain coming up, waiting for the host to prove it is alive) and `PM_ACT` (normal running). Supply-valid and fault conditions arrive as synchronous flags. The shutdown, on-key, two reset GPIOs, keep-active and system-enable pins are asynchronous and are each passed through a two-flop synchroniser before any decision is taken on them.

The transitions are named as follows. T_POWERUP (`PM_OFF`→`PM_RST`) fires when the supply becomes valid. T_SUPPLY_LOSS (any state→`PM_OFF`) fires when it is lost. T_FORCE_RST (`PM_PDN`/`PM_BOOT`/`PM_ACT`→`PM_RST`) fires on any qualified reset source, and T_RST_DONE (`PM_RST`→`PM_PDN`) fires once no reset source remains. T_WAKE (`PM_PDN`→`PM_BOOT`) fires on a wake event and emits a reload-defaults pulse. T_ALIVE (`PM_BOOT`→`PM_ACT`) fires on the host handshake, and T_WIN_EXPIRE (`PM_BOOT`→`PM_RST`) fires when the handshake window runs out. T_SLEEP (`PM_BOOT`/`PM_ACT`→`PM_PDN`) fires on a host low-power request or on a low system-enable. When several transitions compete, supply loss wins first, then reset sources, then sleep requests, then wake and alive events.

The surrounding chip uses the mode code, the watchdog-supervision enable, the per-feature clock enables and the oscillator request to gate its regulators and digital logic. It uses the reload and sequencer-pointer pulses to restore its default voltages and start-up order after a wake.

Top module: `pmic_mode_ctrl`

## Requirements
- R1: After `rst_n` the mode is `PM_OFF` and every output is low. Mode codes on `mode_o` are OFF=0, RST=1, PDN=2, BOOT=3, ACT=4. A low `supply_ok` forces `PM_OFF` on the next clock edge from any state, ahead of every other request.
- R2: In `PM_OFF` a high `supply_ok` moves the block to `PM_RST` on the next edge. `PM_RST` holds while any reset source is present and moves to `PM_PDN` on the first edge with none.
- R3: A high `uv_flt`, `ot_flt` or `boost_flt` (with the supply valid) gives `PM_RST` on the next edge. This also holds when a low-power request is made in the same cycle.
- R4: A low `shutdown_n` gives `PM_RST` on the third edge after it is applied, once through the synchroniser. The block stays in `PM_RST` while the pin is low.
- R5: With `cfg_onkey_rst_en` high, `onkey_n` held low for LONG_CYC consecutive synchronised cycles forces `PM_RST`. A release before that restarts the count. With the enable low, a held key never forces a reset.
- R6: With `cfg_gpio_rst_en` high, `gpio_rst_a` and `gpio_rst_b` both held high for LONG_CYC consecutive synchronised cycles force `PM_RST`. Either pin alone has no effect.
- R7: `wdog_flt` forces `PM_RST` only in `PM_BOOT` and `PM_ACT`. In `PM_PDN` it is ignored.
- R8: In `PM_PDN` a wake event moves the block to `PM_BOOT`, and `reload_pls_o` is high for exactly the first `PM_BOOT` cycle. A wake event is either a high synchronised `sys_en` while not parked by a host request, or a new on-key press edge.
- R9: `seq_ptr_clr_o` is high together with `reload_pls_o` exactly when `sys_en` was low at entry to, or at any time during, the `PM_PDN` stay that the wake ends.
- R10: In `PM_BOOT`, `alive_wr` (flag, next edge), `keep_act` (pin, third edge) or a high `cfg_alive_skip` moves the block to `PM_ACT`. Without one of them, the block moves to `PM_RST` after exactly WIN_CYC cycles in `PM_BOOT`.
- R11: `PM_BOOT` and `PM_ACT` go to `PM_PDN` on a `host_lp_req` pulse (next edge) or a low `sys_en` (third edge). After a host request made with `sys_en` high, the block stays parked in `PM_PDN` until an on-key press or a low phase of `sys_en`.
- R12: `wdog_en_o` is high exactly in `PM_BOOT` and `PM_ACT`. `feat_clk_en_o` is all ones in `PM_BOOT`/`PM_ACT`, equals `feat_on` in `PM_PDN`, and is zero in `PM_OFF`/`PM_RST`. `osc_req_o` is the OR of `feat_clk_en_o` masked by OSC_USERS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| supply_ok | input | 1 | Supply-valid flag |
| uv_flt | input | 1 | Output under-voltage flag |
| ot_flt | input | 1 | Die over-temperature flag |
| boost_flt | input | 1 | Boost over-voltage or over-current flag |
| wdog_flt | input | 1 | Host watchdog timing violation flag |
| shutdown_n | input | 1 | Asynchronous shutdown pin, active low |
| onkey_n | input | 1 | Asynchronous on-key pin, active low |
| gpio_rst_a | input | 1 | First reset GPIO, active high |
| gpio_rst_b | input | 1 | Second reset GPIO, active high |
| keep_act | input | 1 | Asynchronous keep-active pin |
| sys_en | input | 1 | Asynchronous system-domain enable pin |
| host_lp_req | input | 1 | Host low-power request pulse |
| alive_wr | input | 1 | Host alive watchdog write pulse |
| cfg_alive_skip | input | 1 | Bypass the alive handshake |
| cfg_onkey_rst_en | input | 1 | Enable on-key long-press reset |
| cfg_gpio_rst_en | input | 1 | Enable dual-GPIO long-hold reset |
| feat_on | input | N_FEAT | Features enabled for low-power operation |
| mode_o | output | 3 | Current mode code |
| wdog_en_o | output | 1 | Watchdog supervision enable |
| feat_clk_en_o | output | N_FEAT | Per-feature clock enables |
| osc_req_o | output | 1 | Internal oscillator request |
| reload_pls_o | output | 1 | Reload-defaults pulse on wake |
| seq_ptr_clr_o | output | 1 | Sequencer pointer reset to position 0 |

## Verification
A wrong state register shows at once on `mode_o` and through the decoded watchdog and clock enables in the same cycle. The bench therefore checks the mode at the exact edge each transition is due: one edge after a flag, three edges after a pin, and LONG_CYC plus three edges after a long hold starts. A corrupt hold counter or window counter shows as a reset that arrives one or more cycles early or late. A wrong park or cause flag stays hidden until the next wake, where it shows as a missing or spurious wake, a missing or spurious sequencer-pointer pulse, or both.

// File: rtl/pmic_mode_pkg.sv
package pmic_mode_pkg;

    typedef enum logic [2:0] {
        PM_OFF  = 3'd0,
        PM_RST  = 3'd1,
        PM_PDN  = 3'd2,
        PM_BOOT = 3'd3,
        PM_ACT  = 3'd4
    } pm_mode_e;

    // Positions in the synchronised pin vector
    localparam int unsigned PIN_SHDN_N  = 0;
    localparam int unsigned PIN_ONKEY_N = 1;
    localparam int unsigned PIN_GPIO_A  = 2;
    localparam int unsigned PIN_GPIO_B  = 3;
    localparam int unsigned PIN_KEEP    = 4;
    localparam int unsigned PIN_SYSEN   = 5;
    localparam int unsigned PIN_COUNT   = 6;

    // Idle levels loaded into the synchronisers during reset
    localparam logic [PIN_COUNT-1:0] PIN_IDLE = 6'b00_0011;

    // Long-hold detector slots
    localparam int unsigned HOLD_ONKEY = 0;
    localparam int unsigned HOLD_GPIO  = 1;
    localparam int unsigned HOLD_COUNT = 2;

endpackage

// File: rtl/pmic_pin_sync.sv
module pmic_pin_sync #(
    parameter int unsigned    W    = 1,
    parameter logic [W-1:0]   IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= IDLE;
            sync_q <= IDLE;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    assign pin_o = sync_q;

endmodule

// File: rtl/pmic_hold_det.sv
module pmic_hold_det #(
    parameter int unsigned HOLD_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic hit_o
);

    localparam int unsigned    CW    = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0]  LIMIT = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;

    // Counts consecutive cycles of level_i, saturating at LIMIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!level_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit_o = (cnt_q == LIMIT);

endmodule

// File: rtl/pmic_alive_win.sv
module pmic_alive_win #(
    parameter int unsigned WIN_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int unsigned   CW   = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // High in the last cycle of the window
    assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/pmic_mode_ctrl.sv
module pmic_mode_ctrl
    import pmic_mode_pkg::*;
#(
    parameter int unsigned N_FEAT    = 4,
    parameter int unsigned LONG_CYC  = 4096,
    parameter int unsigned WIN_CYC   = 1024,
    parameter int unsigned OSC_USERS = 32'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              uv_flt,
    input  logic              ot_flt,
    input  logic              boost_flt,
    input  logic              wdog_flt,
    input  logic              shutdown_n,
    input  logic              onkey_n,
    input  logic              gpio_rst_a,
    input  logic              gpio_rst_b,
    input  logic              keep_act,
    input  logic              sys_en,
    input  logic              host_lp_req,
    input  logic              alive_wr,
    input  logic              cfg_alive_skip,
    input  logic              cfg_onkey_rst_en,
    input  logic              cfg_gpio_rst_en,
    input  logic [N_FEAT-1:0] feat_on,
    output logic [2:0]        mode_o,
    output logic              wdog_en_o,
    output logic [N_FEAT-1:0] feat_clk_en_o,
    output logic              osc_req_o,
    output logic              reload_pls_o,
    output logic              seq_ptr_clr_o
);

    localparam logic [N_FEAT-1:0] OSC_MASK = N_FEAT'(OSC_USERS);

    // ---------------- pin synchronisation ----------------
    logic [PIN_COUNT-1:0] pin_raw;
    logic [PIN_COUNT-1:0] pin_s;

    always_comb begin
        pin_raw              = '0;
        pin_raw[PIN_SHDN_N]  = shutdown_n;
        pin_raw[PIN_ONKEY_N] = onkey_n;
        pin_raw[PIN_GPIO_A]  = gpio_rst_a;
        pin_raw[PIN_GPIO_B]  = gpio_rst_b;
        pin_raw[PIN_KEEP]    = keep_act;
        pin_raw[PIN_SYSEN]   = sys_en;
    end

    pmic_pin_sync #(
        .W    (PIN_COUNT),
        .IDLE (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_raw),
        .pin_o (pin_s)
    );

    logic key_down;
    logic sysen_s;
    logic keep_s;
    assign key_down = ~pin_s[PIN_ONKEY_N];
    assign sysen_s  = pin_s[PIN_SYSEN];
    assign keep_s   = pin_s[PIN_KEEP];

    // ---------------- long-hold qualification ----------------
    logic [HOLD_COUNT-1:0] hold_lvl;
    logic [HOLD_COUNT-1:0] hold_hit;

    always_comb begin
        hold_lvl             = '0;
        hold_lvl[HOLD_ONKEY] = cfg_onkey_rst_en & key_down;
        hold_lvl[HOLD_GPIO]  = cfg_gpio_rst_en & pin_s[PIN_GPIO_A] & pin_s[PIN_GPIO_B];
    end

    for (genvar g = 0; g < HOLD_COUNT; g++) begin : g_hold
        pmic_hold_det #(
            .HOLD_CYC (LONG_CYC)
        ) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (hold_lvl[g]),
            .hit_o   (hold_hit[g])
        );
    end

    // ---------------- state ----------------
    pm_mode_e state_q, state_d;
    logic     park_q;      // parked in PDN by a host request
    logic     cause_q;     // PDN stay saw a low system enable
    logic     key_prev_q;  // on-key pressed in the previous cycle

    // ---------------- alive window ----------------
    logic in_boot;
    logic win_exp;
    assign in_boot = (state_q == PM_BOOT);

    pmic_alive_win #(
        .WIN_CYC (WIN_CYC)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (in_boot),
        .expired_o (win_exp)
    );

    // ---------------- transition qualifiers ----------------
    logic supervised;
    logic rst_any;
    logic sleep_req;
    logic key_edge;
    logic wake_evt;
    logic alive_evt;
    logic enter_pdn;

    assign supervised = (state_q == PM_BOOT) || (state_q == PM_ACT);
    assign rst_any    = ~pin_s[PIN_SHDN_N] | (|hold_hit) | (wdog_flt & supervised)
                      | uv_flt | ot_flt | boost_flt | win_exp;
    assign sleep_req  = host_lp_req | ~sysen_s;
    assign key_edge   = key_down & ~key_prev_q;
    assign wake_evt   = key_edge | (sysen_s & ~park_q);
    assign alive_evt  = alive_wr | keep_s | cfg_alive_skip;
    assign enter_pdn  = (state_d == PM_PDN) && (state_q != PM_PDN);

    // Priority: supply loss > reset sources > sleep requests > wake / alive
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_OFF: begin
                if (supply_ok) state_d = PM_RST;
            end
            PM_RST: begin
                if (!rst_any) state_d = PM_PDN;
            end
            PM_PDN: begin
                if (rst_any)       state_d = PM_RST;
                else if (wake_evt) state_d = PM_BOOT;
            end
            PM_BOOT: begin
                if (rst_any)        state_d = PM_RST;
                else if (sleep_req) state_d = PM_PDN;
                else if (alive_evt) state_d = PM_ACT;
            end
            PM_ACT: begin
                if (rst_any)        state_d = PM_RST;
                else if (sleep_req) state_d = PM_PDN;
            end
            default: state_d = PM_OFF;
        endcase
        if (!supply_ok) state_d = PM_OFF;
    end

    // State register and low-power bookkeeping flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= PM_OFF;
            park_q     <= 1'b0;
            cause_q    <= 1'b0;
            key_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            key_prev_q <= key_down;
            if (enter_pdn) begin
                park_q  <= host_lp_req & sysen_s;
                cause_q <= ~sysen_s;
            end else if (state_q == PM_PDN) begin
                if (!sysen_s || key_edge) park_q <= 1'b0;
                if (!sysen_s)             cause_q <= 1'b1;
            end
        end
    end

    // ---------------- outputs ----------------
    logic wake_now;
    assign wake_now = (state_q == PM_PDN) && (state_d == PM_BOOT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_pls_o  <= 1'b0;
            seq_ptr_clr_o <= 1'b0;
        end else begin
            reload_pls_o  <= wake_now;
            seq_ptr_clr_o <= wake_now & (cause_q | ~sysen_s);
        end
    end

    always_comb begin
        wdog_en_o     = 1'b0;
        feat_clk_en_o = '0;
        unique case (state_q)
            PM_BOOT, PM_ACT: begin
                wdog_en_o     = 1'b1;
                feat_clk_en_o = '1;
            end
            PM_PDN: begin
                feat_clk_en_o = feat_on;
            end
            default: begin
                wdog_en_o     = 1'b0;
                feat_clk_en_o = '0;
            end
        endcase
    end

    assign osc_req_o = |(feat_clk_en_o & OSC_MASK);
    assign mode_o    = state_q;

endmodule

// File: rtl/pmic_mode_chk.sv
module pmic_mode_chk
    import pmic_mode_pkg::*;
#(
    parameter int unsigned N_FEAT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              uv_flt,
    input logic              ot_flt,
    input logic              boost_flt,
    input logic [2:0]        mode_o,
    input logic              wdog_en_o,
    input logic [N_FEAT-1:0] feat_clk_en_o,
    input logic              reload_pls_o,
    input logic              seq_ptr_clr_o
);

    // R1: supply loss wins over everything
    a_r1_supply_loss_off: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (mode_o == PM_OFF));

    // R3: fault flags force reset on the next edge
    a_r3_flag_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && (uv_flt || ot_flt || boost_flt)) |=> (mode_o == PM_RST));

    // R8: reload pulse only in the first cycle after leaving PDN for BOOT
    a_r8_reload_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pls_o |-> ((mode_o == PM_BOOT) && ($past(mode_o) == PM_PDN)));

    // R9: pointer reset never without a reload
    a_r9_seq_clr_with_reload: assert property (@(posedge clk) disable iff (!rst_n)
        seq_ptr_clr_o |-> reload_pls_o);

    // R10: ACT is only reached through BOOT
    a_r10_active_via_boot: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == PM_ACT) |-> (($past(mode_o) == PM_BOOT) || ($past(mode_o) == PM_ACT)));

    // R12: no watchdog supervision while in PDN
    a_r12_pdn_no_wdog: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == PM_PDN) |-> !wdog_en_o);

    // R12: everything gated in OFF and RST
    a_r12_gated_when_down: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == PM_OFF) || (mode_o == PM_RST)) |-> (feat_clk_en_o == '0));

endmodule

bind pmic_mode_ctrl pmic_mode_chk #(
    .N_FEAT (N_FEAT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok     (supply_ok),
    .uv_flt        (uv_flt),
    .ot_flt        (ot_flt),
    .boost_flt     (boost_flt),
    .mode_o        (mode_o),
    .wdog_en_o     (wdog_en_o),
    .feat_clk_en_o (feat_clk_en_o),
    .reload_pls_o  (reload_pls_o),
    .seq_ptr_clr_o (seq_ptr_clr_o)
);

// File: tb/sim_pmic_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pmic_mode_ctrl;

    localparam int NF   = 4;
    localparam int LONG = 8;
    localparam int WIN  = 16;
    localparam int OSCM = 3;

    localparam int M_OFF  = 0;
    localparam int M_RST  = 1;
    localparam int M_PDN  = 2;
    localparam int M_BOOT = 3;
    localparam int M_ACT  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 0, uv_flt = 0, ot_flt = 0, boost_flt = 0, wdog_flt = 0;
    logic shutdown_n = 1, onkey_n = 1, gpio_rst_a = 0, gpio_rst_b = 0, keep_act = 0, sys_en = 1;
    logic host_lp_req = 0, alive_wr = 0, cfg_alive_skip = 0, cfg_onkey_rst_en = 1, cfg_gpio_rst_en = 1;
    logic [NF-1:0] feat_on = 4'b0101;
    logic [2:0]    mode_o;
    logic          wdog_en_o, osc_req_o, reload_pls_o, seq_ptr_clr_o;
    logic [NF-1:0] feat_clk_en_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pmic_mode_ctrl #(
        .N_FEAT(NF), .LONG_CYC(LONG), .WIN_CYC(WIN), .OSC_USERS(OSCM)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .uv_flt(uv_flt), .ot_flt(ot_flt),
        .boost_flt(boost_flt), .wdog_flt(wdog_flt), .shutdown_n(shutdown_n), .onkey_n(onkey_n),
        .gpio_rst_a(gpio_rst_a), .gpio_rst_b(gpio_rst_b), .keep_act(keep_act), .sys_en(sys_en),
        .host_lp_req(host_lp_req), .alive_wr(alive_wr), .cfg_alive_skip(cfg_alive_skip),
        .cfg_onkey_rst_en(cfg_onkey_rst_en), .cfg_gpio_rst_en(cfg_gpio_rst_en), .feat_on(feat_on),
        .mode_o(mode_o), .wdog_en_o(wdog_en_o), .feat_clk_en_o(feat_clk_en_o), .osc_req_o(osc_req_o),
        .reload_pls_o(reload_pls_o), .seq_ptr_clr_o(seq_ptr_clr_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected decoded outputs for a mode (R12)
    task automatic chk_mode(input string req, input int exp);
        int ck;
        int osc;
        chk(req, "mode", int'(mode_o), exp);
        chk(req, "wdog_en", int'(wdog_en_o), (exp == M_BOOT || exp == M_ACT) ? 1 : 0);
        ck = (exp == M_BOOT || exp == M_ACT) ? (1 << NF) - 1 : (exp == M_PDN) ? int'(feat_on) : 0;
        chk(req, "clk_en", int'(feat_clk_en_o), ck);
        osc = ((ck & OSCM) != 0) ? 1 : 0;
        chk(req, "osc_req", int'(osc_req_o), osc);
    endtask

    task automatic alive_pulse();
        alive_wr = 1; tick(1); alive_wr = 0;
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(3);
        // R1: reset state
        chk_mode("R1", M_OFF);
        chk("R1", "reload", int'(reload_pls_o), 0);
        chk("R1", "seq_clr", int'(seq_ptr_clr_o), 0);

        // R2: power-up through RST and PDN, then wake (R8)
        supply_ok = 1;
        tick(1); chk_mode("R2", M_RST);
        tick(1); chk_mode("R2", M_PDN);
        tick(1); chk_mode("R8", M_BOOT);
        chk("R8", "reload", int'(reload_pls_o), 1);
        chk("R9", "seq_clr", int'(seq_ptr_clr_o), 0);
        tick(1); chk("R8", "reload width", int'(reload_pls_o), 0);

        // R10: window expiry after exactly WIN cycles in BOOT
        tick(WIN - 2); chk_mode("R10", M_BOOT);
        tick(1); chk_mode("R10", M_RST);
        tick(1); chk_mode("R2", M_PDN);
        tick(1); chk_mode("R8", M_BOOT);
        chk("R8", "reload", int'(reload_pls_o), 1);

        // R10: alive write
        alive_pulse(); chk_mode("R10", M_ACT);

        // R11: host request parks PDN
        host_lp_req = 1; tick(1); host_lp_req = 0;
        chk_mode("R11", M_PDN);
        tick(4); chk_mode("R11", M_PDN);
        feat_on = 4'b0100; tick(1); chk_mode("R12", M_PDN);
        feat_on = 4'b0101;

        // R7: watchdog fault ignored in PDN
        wdog_flt = 1; tick(2); chk_mode("R7", M_PDN); wdog_flt = 0;

        // R8: on-key press wakes a parked PDN
        onkey_n = 0; tick(1); onkey_n = 1;
        tick(1); chk_mode("R8", M_PDN);
        tick(1); chk_mode("R8", M_BOOT);
        chk("R8", "reload", int'(reload_pls_o), 1);
        chk("R9", "seq_clr", int'(seq_ptr_clr_o), 0);

        // R10: keep-active pin (third edge)
        keep_act = 1; tick(1); keep_act = 0;
        tick(1); chk_mode("R10", M_BOOT);
        tick(1); chk_mode("R10", M_ACT);

        // R11 / R9: system enable low then high
        sys_en = 0;
        tick(2); chk_mode("R11", M_ACT);
        tick(1); chk_mode("R11", M_PDN);
        tick(2); chk_mode("R11", M_PDN);
        sys_en = 1;
        tick(3); chk_mode("R9", M_BOOT);
        chk("R9", "reload", int'(reload_pls_o), 1);
        chk("R9", "seq_clr", int'(seq_ptr_clr_o), 1);

        // R10: handshake bypass
        cfg_alive_skip = 1; tick(1); cfg_alive_skip = 0;
        chk_mode("R10", M_ACT);

        // R3: under-voltage beats a same-cycle low-power request
        uv_flt = 1; host_lp_req = 1;
        tick(1); chk_mode("R3", M_RST);
        tick(1); chk_mode("R3", M_RST);
        uv_flt = 0; host_lp_req = 0;
        tick(1); chk_mode("R2", M_PDN);
        tick(1); chk_mode("R8", M_BOOT);
        alive_pulse();

        // R3: over-temperature and boost flags
        ot_flt = 1; tick(1); ot_flt = 0; chk_mode("R3", M_RST);
        tick(2); alive_pulse(); chk_mode("R10", M_ACT);
        boost_flt = 1; tick(1); boost_flt = 0; chk_mode("R3", M_RST);
        tick(2); alive_pulse();

        // R4: shutdown pin
        shutdown_n = 0;
        tick(2); chk_mode("R4", M_ACT);
        tick(1); chk_mode("R4", M_RST);
        tick(3); chk_mode("R4", M_RST);
        shutdown_n = 1;
        tick(2); chk_mode("R4", M_RST);
        tick(1); chk_mode("R2", M_PDN);
        tick(1); alive_pulse(); chk_mode("R10", M_ACT);

        // R7: watchdog fault in ACT
        wdog_flt = 1; tick(1); wdog_flt = 0; chk_mode("R7", M_RST);
        tick(1); chk_mode("R7", M_PDN);
        tick(1); alive_pulse();

        // R5: long press forces reset after LONG synchronised cycles
        onkey_n = 0;
        tick(LONG + 2); chk_mode("R5", M_ACT);
        tick(1); chk_mode("R5", M_RST);
        onkey_n = 1;
        tick(3); chk_mode("R5", M_RST);
        tick(1); chk_mode("R5", M_PDN);
        tick(1); alive_pulse(); chk_mode("R5", M_ACT);

        // R5: interrupted presses restart the count
        onkey_n = 0; tick(LONG - 3); onkey_n = 1; tick(1);
        onkey_n = 0; tick(LONG - 3); onkey_n = 1;
        tick(4); chk_mode("R5", M_ACT);

        // R5: disabled long press is ignored
        cfg_onkey_rst_en = 0; onkey_n = 0;
        tick(LONG + 6); chk_mode("R5", M_ACT);
        onkey_n = 1; tick(4); cfg_onkey_rst_en = 1;

        // R6: a single GPIO has no effect, both together reset
        gpio_rst_a = 1;
        tick(LONG + 6); chk_mode("R6", M_ACT);
        gpio_rst_b = 1;
        tick(LONG + 2); chk_mode("R6", M_ACT);
        tick(1); chk_mode("R6", M_RST);
        gpio_rst_a = 0; gpio_rst_b = 0;
        tick(4); chk_mode("R6", M_PDN);
        tick(1); chk_mode("R8", M_BOOT);

        // R1: supply loss
        supply_ok = 0;
        tick(1); chk_mode("R1", M_OFF);
        chk("R1", "reload", int'(reload_pls_o), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule